// File: doc/BRIEF.md
# Endian-Aware Load/Store Aligner

This block sits between a 32-bit datapath and a data memory that is one word wide but addressed by byte. On a load, it takes the full fetched memory word and returns the addressed byte, halfword or word right-justified. A narrow result is filled to 32 bits with copies of its sign bit or with zeros. On a store, it moves the datapath value into the byte lanes the access covers and produces a matching four-bit byte-enable mask for the memory write port.

A run-time mode input selects big-endian or little-endian byte numbering inside the word. An access whose address is not a multiple of its size is not performed. The block raises a fault flag, drives no byte enables and returns zero load data. The whole block is combinational. Its outputs depend only on the present inputs.

Top module: `lsa_top`

## Requirements
- R1: Little-endian mode (big_endian_i=0): a byte access at address offset k (addr_i[1:0]) uses word bits [8k+7:8k].
- R2: Big-endian mode (big_endian_i=1): a byte access at address offset k uses word bits [8(3-k)+7:8(3-k)].
- R3: For halfword and word accesses, the byte at the lowest address is the least significant byte of the value in little-endian mode and the most significant byte in big-endian mode.
- R4: With sign_ext_i=1, a byte or halfword load fills the upper result bits with the value's top bit. With sign_ext_i=0 the upper bits are zero. A word load ignores sign_ext_i.
- R5: misalign_o is 1 for a halfword with addr_i[0]=1 and for a word with addr_i[1:0]!=0. It is never 1 for a byte access.
- R6: While misalign_o is 1, byte_en_o is 0000 and load_data_o is zero.
- R7: For an aligned access, byte_en_o has one bit set for a byte, two adjacent bits for a halfword and all four bits for a word. The bit for the byte at offset k is bit k in little-endian mode and bit 3-k in big-endian mode.
- R8: On an aligned access, wr_word_o holds the low bytes of wr_data_i in the enabled lanes, ordered by the same endianness rule as loads. Every lane not enabled is zero.
- R9: size_i encoding is 00 for byte, 01 for halfword, and 10 or 11 for word.
- R10: All outputs follow the inputs in the same cycle. addr_i bits above bit 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| big_endian_i | input | 1 | 1 selects big-endian byte numbering, 0 little-endian |
| size_i | input | 2 | Access size code (R9) |
| sign_ext_i | input | 1 | Sign-extend narrow loads when 1 |
| addr_i | input | 32 | Byte address of the access |
| rd_word_i | input | 32 | Word fetched from memory for a load |
| wr_data_i | input | 32 | Right-justified store value from the datapath |
| load_data_o | output | 32 | Aligned and extended load result |
| wr_word_o | output | 32 | Store data placed in its byte lanes |
| byte_en_o | output | 4 | Per-lane write enables, bit n covers bits [8n+7:8n] |
| misalign_o | output | 1 | Access is not aligned to its size |

## Verification
The assertions take every input as a defined two-state value once the bench starts. They do not assume that the upper address bits or the unused lanes of wr_data_i are zero. The bench keeps within this by driving every input from time zero. It first sweeps all size codes, offsets, modes and extend settings with fixed patterns whose top bits are set. It then applies random words and addresses with random upper bits. As a result, sign fill, lane placement and fault masking are all observed with non-zero values in the bytes that must be discarded.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    // Which lanes an access occupies, and whether it may proceed.
    typedef struct packed {
        logic [OFF_W-1:0] lo_lane;
        logic [OFF_W:0]   nbytes;
        logic             fault;
    } lane_plan_t;

    function automatic logic [OFF_W:0] size_to_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return (OFF_W+1)'(1);
            SZ_HALF: return (OFF_W+1)'(2);
            default: return (OFF_W+1)'(LANES);
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(logic [OFF_W:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/lsa_lane_planner.sv
module lsa_lane_planner
    import lsa_pkg::*;
(
    input  logic [OFF_W-1:0] offset_i,
    input  acc_size_e        size_i,
    input  logic             big_endian_i,
    output lane_plan_t       plan_o
);
    logic [OFF_W:0] nb;
    logic           bad;
    logic [OFF_W:0] big_lo;

    always_comb begin
        nb     = size_to_bytes(size_i);
        bad    = ({1'b0, offset_i} & (nb - 1'b1)) != '0;
        big_lo = (OFF_W+1)'(LANES) - {1'b0, offset_i} - nb;
        plan_o.nbytes  = nb;
        plan_o.fault   = bad;
        if (bad)
            plan_o.lo_lane = '0;
        else if (big_endian_i)
            plan_o.lo_lane = big_lo[OFF_W-1:0];
        else
            plan_o.lo_lane = offset_i;
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0] rd_word_i,
    input  lane_plan_t        plan_i,
    input  logic              sign_ext_i,
    output logic [WORD_W-1:0] data_o
);
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] keep;
    logic              top_bit;

    always_comb begin
        shifted = rd_word_i >> {plan_i.lo_lane, 3'b000};
        keep    = '0;
        for (int l = 0; l < LANES; l++)
            keep[8*l +: 8] = {8{l < int'(plan_i.nbytes)}};
        top_bit = shifted[8*int'(plan_i.nbytes) - 1];
        if (plan_i.fault)
            data_o = '0;
        else
            data_o = (shifted & keep) | ((sign_ext_i && top_bit) ? ~keep : '0);
    end

    always_comb begin
        if (plan_i.fault)
            a_r6_load_zero: assert (data_o == '0);
    end
endmodule

// File: rtl/lsa_store_place.sv
module lsa_store_place
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0] wr_data_i,
    input  lane_plan_t        plan_i,
    output logic [WORD_W-1:0] wr_word_o,
    output logic [LANES-1:0]  byte_en_o
);
    logic [LANES-1:0]  en_low;
    logic [WORD_W-1:0] low_bytes;

    always_comb begin
        en_low = lane_mask(plan_i.nbytes);
        for (int l = 0; l < LANES; l++)
            low_bytes[8*l +: 8] = en_low[l] ? wr_data_i[8*l +: 8] : 8'h00;
    end

    assign byte_en_o = plan_i.fault ? '0 : (en_low << plan_i.lo_lane);
    assign wr_word_o = plan_i.fault ? '0 : (low_bytes << {plan_i.lo_lane, 3'b000});

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        always_comb begin
            if (!byte_en_o[g])
                a_r8_idle_lane_zero: assert (wr_word_o[8*g +: 8] == 8'h00);
        end
    end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
(
    input  logic        big_endian_i,
    input  logic [1:0]  size_i,
    input  logic        sign_ext_i,
    input  logic [31:0] addr_i,
    input  logic [31:0] rd_word_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] load_data_o,
    output logic [31:0] wr_word_o,
    output logic [3:0]  byte_en_o,
    output logic        misalign_o
);
    lane_plan_t plan;
    acc_size_e  size_e;

    assign size_e = acc_size_e'(size_i);

    lsa_lane_planner u_plan (
        .offset_i     (addr_i[OFF_W-1:0]),
        .size_i       (size_e),
        .big_endian_i (big_endian_i),
        .plan_o       (plan)
    );

    lsa_load_extract u_load (
        .rd_word_i  (rd_word_i),
        .plan_i     (plan),
        .sign_ext_i (sign_ext_i),
        .data_o     (load_data_o)
    );

    lsa_store_place u_store (
        .wr_data_i (wr_data_i),
        .plan_i    (plan),
        .wr_word_o (wr_word_o),
        .byte_en_o (byte_en_o)
    );

    assign misalign_o = plan.fault;

    always_comb begin
        if (misalign_o)
            a_r6_no_enable_on_fault: assert (byte_en_o == '0);
        if (size_i == 2'b00)
            a_r5_byte_never_faults: assert (!misalign_o);
        if (!misalign_o && size_i == 2'b00)
            a_r7_byte_onehot: assert ($countones(byte_en_o) == 1);
        if (!misalign_o && size_i == 2'b01)
            a_r7_half_two: assert ($countones(byte_en_o) == 2);
        if (!misalign_o && size_i[1])
            a_r7_word_all: assert (byte_en_o == 4'hF);
    end
endmodule

// File: tb/lsa_top_tb_top.sv
module lsa_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_endian_i = 1'b0;
    logic [1:0]  size_i = 2'b00;
    logic        sign_ext_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] rd_word_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] load_data_o;
    logic [31:0] wr_word_o;
    logic [3:0]  byte_en_o;
    logic        misalign_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_top dut_i (
        .big_endian_i (big_endian_i),
        .size_i       (size_i),
        .sign_ext_i   (sign_ext_i),
        .addr_i       (addr_i),
        .rd_word_i    (rd_word_i),
        .wr_data_i    (wr_data_i),
        .load_data_o  (load_data_o),
        .wr_word_o    (wr_word_o),
        .byte_en_o    (byte_en_o),
        .misalign_o   (misalign_o)
    );

    function automatic logic [7:0] mem_byte(logic [31:0] w, bit big, int k);
        int lane = big ? 3 - k : k;
        return w[8*lane +: 8];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(bit big, logic [1:0] sz, bit sx, logic [31:0] a,
                         logic [31:0] rw, logic [31:0] wd);
        int n, off;
        bit bad;
        logic [31:0] v, exp_ld, exp_ww;
        logic [3:0]  exp_be;
        string ltag, stag;
        @(posedge clk);
        big_endian_i = big; size_i = sz; sign_ext_i = sx;
        addr_i = a; rd_word_i = rw; wr_data_i = wd;
        // reference model, from R1..R9
        n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        off = int'(a[1:0]);
        bad = (off % n) != 0;
        v = '0; exp_be = '0; exp_ww = '0;
        if (!bad) begin
            for (int i = 0; i < n; i++) begin
                if (big) v = (v << 8) | 32'(mem_byte(rw, big, off + i));
                else     v = v | (32'(mem_byte(rw, big, off + i)) << (8*i));
            end
            if (n < 4 && sx && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
            for (int i = 0; i < n; i++) begin
                int lane = big ? 3 - (off + i) : off + i;
                exp_be[lane] = 1'b1;
                exp_ww[8*lane +: 8] = big ? wd[8*(n-1-i) +: 8] : wd[8*i +: 8];
            end
        end
        exp_ld = bad ? '0 : v;
        if (bad)                      ltag = "R6 load";
        else if (n < 4 && sx)         ltag = "R4 load";
        else if (n > 1)               ltag = (sz == 2'b11) ? "R9 load" : "R3 load";
        else                          ltag = big ? "R2 load" : "R1 load";
        stag = bad ? "R6 byte_en" : "R7 byte_en";
        @(negedge clk);  // R10: same-cycle result, upper address bits random
        check("R5 misalign", 32'(misalign_o), 32'(bad));
        check(ltag, load_data_o, exp_ld);
        check(stag, 32'(byte_en_o), 32'(exp_be));
        check("R8 wr_word", wr_word_o, exp_ww);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state with all-zero inputs: byte at 0, aligned
        check("R10 reset misalign", 32'(misalign_o), 32'd0);
        check("R10 reset byte_en", 32'(byte_en_o), 32'h1);
        // directed sweep
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++)
                    for (int x = 0; x < 2; x++)
                        apply(bit'(b), 2'(s), bit'(x), {28'hABCDE12, 2'b00, 2'(o)},
                              32'h8F7E_C1A2, 32'h9384_B5A6);
        // R10: upper address bits must not matter
        apply(1'b0, 2'b01, 1'b1, 32'hFFFF_FFFE, 32'h80FF_0011, 32'h0000_BEEF);
        apply(1'b1, 2'b01, 1'b1, 32'h0000_0002, 32'h80FF_0011, 32'h0000_BEEF);
        for (int r = 0; r < 2000; r++)
            apply(bit'($urandom_range(1)), 2'($urandom_range(3)), bit'($urandom_range(1)),
                  $urandom, $urandom, $urandom);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule